// File: doc/BRIEF.md
# Two-Master Latched Interrupt Aggregator

This block collects 112 interrupt sources into one host interrupt line. The sources are grouped eight to a block and seven blocks to a master, which gives two masters. A rising edge on any source sets a sticky pending bit. Every block has its own fixed set of registers on a byte-wide register bus with a 10-bit address: latched status, write-one-to-clear acknowledge, mask, and the live line level. There is no indexed block-select step.

Each master has a summary byte. Bits 7:1 of a summary byte flag, for blocks 1 to 7 of that master, that the block holds an unmasked pending source. Bit 0 of master 0's summary is set while master 1's summary is nonzero. A host can therefore start at master 0's summary, follow bit 0 to master 1 only when needed, then read the status of each flagged block and acknowledge it. The host interrupt is high while either summary is nonzero.

The register map is computed from two master base addresses, 0x130 and 0x1B0. For block b (1..7) of a master with base B, latched status is at B+b, acknowledge at B+b+1, mask at B+b+8 and live level at B+b+15. The summary byte is at B itself. Some read and write addresses coincide: the acknowledge address of block b is the status address of block b+1.

Top module: `irqc_top`

## Requirements
- R1: A 0-to-1 change of a source between two clock edges sets its latched bit, whether or not the source is masked. A source already high when reset ends counts as a rising event.
- R2: A latched bit stays set after its source falls, until it is acknowledged or reset.
- R3: Writing to B+b+1 clears the latched bits of block b where the write data has a 1 and leaves the others unchanged. If a rising edge on a bit coincides with its acknowledge, the bit stays set.
- R4: The mask byte of block b is written and read back at B+b+8. A 1 masks the source: the source still latches, but it does not reach the summary or the host interrupt.
- R5: Summary bit k (k = 1..7) of a master is 1 when block k of that master holds a latched, unmasked bit. Bit 0 of master 0's summary is 1 when master 1's summary is nonzero. Bit 0 of master 1's summary reads 0.
- R6: Reading B+b+15 returns the present raw level of block b's eight sources, bit i for source i.
- R7: Reading B+b returns block b's latched byte, including at addresses that are also acknowledge addresses. Reading B+8 (acknowledge-only) or any unmapped address returns 0. Writes to status or summary addresses have no effect.
- R8: `irq_out` is a register. It is 1 in the cycle after some summary byte is nonzero, and 0 in the cycle after both are zero.
- R9: Synchronous reset clears every latch, sets every mask bit to 1, and drives `irq_out` and `reg_rdata` to 0.
- R10: Read data appears on `reg_rdata` one clock after `reg_rd` is sampled high and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 112 | Source lines; source s of block b in master m is bit (m*7+b-1)*8+s |
| reg_addr | input | 10 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Host interrupt request |

## Verification
The bench reads addresses that are both an acknowledge and a status location. A design that decoded reads like writes would return 0 there, or would clear the neighbouring block. It writes all ones to a status address and then rereads it, which catches a decoder that treats that address as an acknowledge. It raises a source in the same cycle that source is acknowledged; a clear-wins design would lose that event. It also walks the chain from master 1 into master 0's bit 0 and back out after the acknowledge, because a stale or missing chain bit would leave the host interrupt stuck or silent. A mid-run reset with one source still high checks that the masks return to all ones, and that a line high at reset release is captured but kept off the interrupt.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // what a read address selects
  typedef enum logic [2:0] {
    RK_NONE = 3'd0,
    RK_SUM  = 3'd1,
    RK_STAT = 3'd2,
    RK_MASK = 3'd3,
    RK_LIVE = 3'd4
  } rd_kind_e;

  // per-block offsets added to (master base + block number)
  localparam int OFF_STAT = 0;
  localparam int OFF_ACK  = 1;
  localparam int OFF_MASK = 8;
  localparam int OFF_LIVE = 15;
endpackage

// File: rtl/irqc_addr_dec.sv
module irqc_addr_dec
  import irqc_pkg::*;
#(
  parameter int AW  = 10,
  parameter int NM  = 2,
  parameter int BPM = 7,
  parameter logic [NM*AW-1:0] BASES = {10'h1B0, 10'h130},
  localparam int NBLK = NM * BPM,
  localparam int GW   = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int MW   = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  output logic [NBLK-1:0] ack_stb,
  output logic [NBLK-1:0] msk_stb,
  output rd_kind_e        rd_kind,
  output logic [MW-1:0]   rd_m,
  output logic [GW-1:0]   rd_g
);

  always_comb begin
    logic [AW-1:0] off;
    ack_stb = '0;
    msk_stb = '0;
    rd_kind = RK_NONE;
    rd_m    = '0;
    rd_g    = '0;
    off     = '0;
    for (int m = 0; m < NM; m++) begin
      off = addr - BASES[m*AW +: AW];
      if (off == '0) begin
        rd_kind = RK_SUM;
        rd_m    = MW'(m);
      end
      for (int b = 1; b <= BPM; b++) begin
        // write side: acknowledge and mask
        if (wr && off == AW'(b + OFF_ACK))
          ack_stb[m*BPM + b - 1] = 1'b1;
        if (wr && off == AW'(b + OFF_MASK))
          msk_stb[m*BPM + b - 1] = 1'b1;
        // read side: status, mask, live
        if (off == AW'(b + OFF_STAT)) begin
          rd_kind = RK_STAT;
          rd_g    = GW'(m*BPM + b - 1);
        end
        if (off == AW'(b + OFF_MASK)) begin
          rd_kind = RK_MASK;
          rd_g    = GW'(m*BPM + b - 1);
        end
        if (off == AW'(b + OFF_LIVE)) begin
          rd_kind = RK_LIVE;
          rd_g    = GW'(m*BPM + b - 1);
        end
      end
    end
  end

endmodule

// File: rtl/irqc_block.sv
module irqc_block #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic         ack_stb,
  input  logic         msk_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] msk_q,
  output logic         pend
);

  logic [W-1:0] prev_q;
  logic [W-1:0] rise;
  logic [W-1:0] ack_bits;

  assign rise     = src & ~prev_q;
  assign ack_bits = ack_stb ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      lat_q  <= '0;
      msk_q  <= '1;
    end else begin
      prev_q <= src;
      // a new edge wins over a coincident acknowledge
      lat_q  <= (lat_q & ~ack_bits) | rise;
      if (msk_stb)
        msk_q <= wdata;
    end
  end

  assign pend = |(lat_q & ~msk_q);

endmodule

// File: rtl/irqc_summary.sv
module irqc_summary #(
  parameter int BPM = 7,
  localparam int DW = BPM + 1
) (
  input  logic [BPM-1:0] blk_pend,
  input  logic           chain_in,
  output logic [DW-1:0]  sum
);

  assign sum = {blk_pend, chain_in};

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8,
  parameter int NM = 2,
  parameter logic [NM*AW-1:0] MBASES = {10'h1B0, 10'h130},
  localparam int BPM  = DW - 1,
  localparam int NBLK = NM * BPM,
  localparam int NSRC = NBLK * DW,
  localparam int GW   = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int MW   = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_in,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic [DW-1:0]   reg_wdata,
  input  logic            reg_rd,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_out
);

  logic [NBLK-1:0] ack_stb;
  logic [NBLK-1:0] msk_stb;
  logic [NBLK-1:0] pend;
  rd_kind_e        rd_kind;
  logic [MW-1:0]   rd_m;
  logic [GW-1:0]   rd_g;
  logic [NSRC-1:0] lat_all;
  logic [NSRC-1:0] msk_all;
  logic [DW-1:0]   sum_w [NM];

  irqc_addr_dec #(
    .AW(AW), .NM(NM), .BPM(BPM), .BASES(MBASES)
  ) u_dec (
    .addr    (reg_addr),
    .wr      (reg_wr),
    .ack_stb (ack_stb),
    .msk_stb (msk_stb),
    .rd_kind (rd_kind),
    .rd_m    (rd_m),
    .rd_g    (rd_g)
  );

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    irqc_block #(.W(DW)) u_blk (
      .clk     (clk),
      .rst     (rst),
      .src     (src_in[g*DW +: DW]),
      .ack_stb (ack_stb[g]),
      .msk_stb (msk_stb[g]),
      .wdata   (reg_wdata),
      .lat_q   (lat_all[g*DW +: DW]),
      .msk_q   (msk_all[g*DW +: DW]),
      .pend    (pend[g])
    );
  end

  // each master's bit 0 chains the next master's summary
  for (genvar m = 0; m < NM; m++) begin : g_sum
    logic chain;
    if (m == NM - 1) begin : g_last
      assign chain = 1'b0;
    end else begin : g_mid
      assign chain = |sum_w[m+1];
    end
    irqc_summary #(.BPM(BPM)) u_sum (
      .blk_pend (pend[m*BPM +: BPM]),
      .chain_in (chain),
      .sum      (sum_w[m])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      irq_out <= |sum_w[0];
      if (reg_rd) begin
        case (rd_kind)
          RK_SUM:  reg_rdata <= sum_w[rd_m];
          RK_STAT: reg_rdata <= lat_all[rd_g*DW +: DW];
          RK_MASK: reg_rdata <= msk_all[rd_g*DW +: DW];
          RK_LIVE: reg_rdata <= src_in[rd_g*DW +: DW];
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NSRC = 112,
  parameter int AW   = 10,
  parameter int DW   = 8,
  parameter int NM   = 2,
  parameter logic [NM*AW-1:0] BASES = {10'h1B0, 10'h130}
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] src_in,
  input logic [AW-1:0]   reg_addr,
  input logic            reg_wr,
  input logic            reg_rd,
  input logic [DW-1:0]   reg_rdata,
  input logic            irq_out,
  input logic [NSRC-1:0] lat_q,
  input logic [NSRC-1:0] msk_q
);

  localparam logic [AW-1:0] ACK_ONLY = BASES[AW-1:0] + AW'(8);

  // R9
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (lat_q == '0 && msk_q == '1 && !irq_out && reg_rdata == '0));

  // R2
  latch_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> (($past(lat_q) & ~lat_q) == '0));

  // R1
  edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (|(src_in & ~$past(src_in))) |=> (lat_q != '0));

  // R4
  all_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (msk_q == '1) |=> !irq_out);

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(lat_q != '0));

  // R7
  ack_only_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ACK_ONLY) |=> (reg_rdata == '0));

endmodule

bind irqc_top irqc_chk #(
  .NSRC(NSRC), .AW(AW), .DW(DW), .NM(NM), .BASES(MBASES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_in    (src_in),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_rdata (reg_rdata),
  .irq_out   (irq_out),
  .lat_q     (lat_all),
  .msk_q     (msk_all)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 112;

  // vector kinds
  localparam logic [1:0] K_SRC = 2'd0;
  localparam logic [1:0] K_WR  = 2'd1;
  localparam logic [1:0] K_RD  = 2'd2;
  localparam logic [1:0] K_IRQ = 2'd3;

  // {kind, address-or-block, data-or-expect, requirement}
  localparam int NV = 36;
  localparam logic [23:0] VEC [NV] = '{
    {K_RD,  10'h130, 8'h00, 4'd5},  // R5 summary idle
    {K_RD,  10'h139, 8'hFF, 4'd9},  // R9 mask reset value
    {K_SRC, 10'd0,   8'h05, 4'd1},  // R1 raise m0 blk1 bits 0,2
    {K_RD,  10'h131, 8'h05, 4'd1},  // R1 latched though masked
    {K_RD,  10'h130, 8'h00, 4'd4},  // R4 masked: no summary
    {K_IRQ, 10'd0,   8'h00, 4'd4},  // R4 masked: no irq
    {K_WR,  10'h139, 8'hFE, 4'd4},  // R4 unmask bit 0
    {K_RD,  10'h139, 8'hFE, 4'd4},  // R4 mask readback
    {K_RD,  10'h130, 8'h02, 4'd5},  // R5 block 1 flagged
    {K_IRQ, 10'd0,   8'h01, 4'd8},  // R8 irq raised
    {K_RD,  10'h140, 8'h05, 4'd6},  // R6 live level
    {K_SRC, 10'd0,   8'h00, 4'd2},  // R2 sources fall
    {K_RD,  10'h131, 8'h05, 4'd2},  // R2 latch held
    {K_RD,  10'h140, 8'h00, 4'd6},  // R6 live follows line
    {K_WR,  10'h132, 8'h01, 4'd3},  // R3 ack bit 0
    {K_RD,  10'h131, 8'h04, 4'd3},  // R3 only bit 0 cleared
    {K_RD,  10'h130, 8'h00, 4'd5},  // R5 remaining bit masked
    {K_IRQ, 10'd0,   8'h00, 4'd8},  // R8 irq dropped
    {K_SRC, 10'd1,   8'h80, 4'd1},  // R1 raise m0 blk2 bit 7
    {K_RD,  10'h132, 8'h80, 4'd7},  // R7 shared address reads status
    {K_WR,  10'h131, 8'hFF, 4'd7},  // R7 write to status address
    {K_RD,  10'h131, 8'h04, 4'd7},  // R7 status unchanged
    {K_RD,  10'h132, 8'h80, 4'd7},  // R7 neighbour unchanged
    {K_RD,  10'h138, 8'h00, 4'd7},  // R7 ack-only address
    {K_RD,  10'h000, 8'h00, 4'd7},  // R7 unmapped
    {K_SRC, 10'd13,  8'h10, 4'd1},  // R1 raise m1 blk7 bit 4
    {K_WR,  10'h1BF, 8'hEF, 4'd4},  // R4 unmask it
    {K_RD,  10'h1BF, 8'hEF, 4'd4},  // R4 readback
    {K_RD,  10'h1B0, 8'h80, 4'd5},  // R5 master 1 summary
    {K_RD,  10'h130, 8'h01, 4'd5},  // R5 chain bit
    {K_IRQ, 10'd0,   8'h01, 4'd8},  // R8 irq via master 1
    {K_RD,  10'h1C6, 8'h10, 4'd6},  // R6 master 1 live
    {K_WR,  10'h1B8, 8'h10, 4'd3},  // R3 ack master 1 blk7
    {K_RD,  10'h1B0, 8'h00, 4'd5},  // R5 master 1 clear
    {K_RD,  10'h130, 8'h00, 4'd5},  // R5 chain clear
    {K_IRQ, 10'd0,   8'h00, 4'd8}   // R8 irq dropped
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_in = '0;
  logic [9:0]      reg_addr = '0;
  logic            reg_wr = 1'b0;
  logic [7:0]      reg_wdata = '0;
  logic            reg_rd = 1'b0;
  logic [7:0]      reg_rdata;
  logic            irq_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top u_dut (
    .clk       (clk),
    .rst       (rst),
    .src_in    (src_in),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_rd(input string tag, input logic [9:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(tag, reg_rdata, exp);
    @(negedge clk);
  endtask

  task automatic run_vec(input logic [23:0] v);
    logic [1:0] k;
    logic [9:0] a;
    logic [7:0] d;
    string tag;
    k = v[23:22]; a = v[21:12]; d = v[11:4];
    tag = $sformatf("R%0d", v[3:0]);
    case (k)
      K_SRC: begin
        @(negedge clk);
        src_in[int'(a)*8 +: 8] = d;
        @(negedge clk);
        @(negedge clk);
      end
      K_WR:  do_wr(a, d);
      K_RD:  do_rd(tag, a, d);
      default: begin
        @(negedge clk);
        chk(tag, {7'd0, irq_out}, d);
      end
    endcase
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 outputs after reset
    chk("R9", reg_rdata, 8'h00);
    chk("R9", {7'd0, irq_out}, 8'h00);
    // R10 read data holds without a new read
    do_rd("R10", 10'h139, 8'hFF);
    @(negedge clk);
    chk("R10", reg_rdata, 8'hFF);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R3 edge coincident with acknowledge keeps the bit (blk1 holds 04)
    @(negedge clk);
    src_in[3] = 1'b1;
    reg_wr = 1'b1; reg_addr = 10'h132; reg_wdata = 8'h0C;
    @(negedge clk);
    reg_wr = 1'b0;
    do_rd("R3", 10'h131, 8'h08);
    // R3 zero write leaves latches alone
    do_wr(10'h132, 8'h00);
    do_rd("R3", 10'h131, 8'h08);
    src_in[3] = 1'b0;

    // R9 mid-run reset with m1 blk7 bit 4 still high
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", {7'd0, irq_out}, 8'h00);
    do_rd("R9", 10'h131, 8'h00);
    do_rd("R9", 10'h139, 8'hFF);
    do_rd("R9", 10'h1BF, 8'hFF);
    // R1 line high at reset release is captured, masked off the irq
    do_rd("R1", 10'h1B7, 8'h10);
    do_rd("R5", 10'h1B0, 8'h00);
    chk("R8", {7'd0, irq_out}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule